// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Three-State Parallel Outputs

This block turns a serial bit stream into a parallel word. A chain of shift stages takes one bit per rising edge of a dedicated shift clock. The chain does not reach the pins directly. Instead, a separate storage register copies the whole chain on a rising edge of its own storage clock, and that copy drives the parallel outputs. As a result, a full new word can be shifted in while the pins keep showing the previous word. All pins then change together on a single storage-clock edge.

The parallel outputs are three-state. An active-low enable either drives the stored word or releases every pin to high impedance, so the outputs can share a bus with other drivers. A serial output always carries the last shift stage, whatever the enable is doing, so several instances can be chained into a longer register. An active-low clear empties the shift chain asynchronously and leaves the storage register alone.

When both clocks come from the same edge, the storage register takes the chain contents from before that edge. The pins therefore trail the chain by one clock.

Top module: `sreg_latched_out`

## Requirements
- R1: On each rising edge of `shift_clk` with `clr_n` high, stage k+1 takes the old value of stage k, and stage 0 takes `ser_i`. After eight edges the first bit sent sits in stage 7.
- R2: On each rising edge of `store_clk`, all stages are copied into the storage register. With the outputs enabled, `par_o[i]` shows the stored copy of stage i.
- R3: Between storage-clock edges, `par_o` keeps its value while any number of shift-clock edges occur.
- R4: While `oe_n` is high, every bit of `par_o` is high impedance, so another driver on the same net sets its level. While `oe_n` is low, `par_o` drives the stored word.
- R5: `ser_o` always equals stage 7, and `oe_n` has no effect on it.
- R6: While `clr_n` is low, every shift stage is 0 at once, without waiting for a clock, and shift-clock edges do not load data.
- R7: `clr_n` does not change the storage register. The pins keep the old word until a later `store_clk` edge copies the cleared stages.
- R8: When `shift_clk` and `store_clk` rise on the same edge, the storage register receives the stage contents from just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; stages advance on its rising edge |
| store_clk | input | 1 | Storage clock; copies the stages to the storage register on its rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| ser_i | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Parallel output enable, active low |
| par_o | output | 8 | Three-state parallel outputs from the storage register |
| ser_o | output | 1 | Unbuffered copy of the last shift stage, for cascading |

## Verification
A fault in the shift chain shows on `ser_o` within at most eight shift edges. It also shows on `par_o` at the first storage edge after the faulty bits arrive. A storage register that updates when it should not shows up immediately as a change on `par_o` during a run of shift edges. A fault in the three-state control shows up immediately as a conflict with a second driver on the shared net. The same-edge case is checked directly by firing both clocks together and comparing `par_o` with the word the chain held one edge earlier.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    // Default number of stages in one instance.
    localparam int unsigned SREG_DEF_WIDTH = 8;

    // Drive state of the parallel pins, named from the enable level.
    typedef enum logic {
        DRIVE_ON  = 1'b0,
        DRIVE_OFF = 1'b1
    } drive_e;
endpackage

// File: rtl/sreg_stage_chain.sv
module sreg_stage_chain #(
    parameter int unsigned WIDTH = sreg_pkg::SREG_DEF_WIDTH
) (
    input  logic             shift_clk,
    input  logic             clr_n,
    input  logic             ser_i,
    output logic [WIDTH-1:0] stage_o
);
    localparam int unsigned TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stage;
    } chain_t;

    chain_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.stage = {r_q.stage[TOP-1:0], ser_i};
    end

    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stage_o = r_q.stage;

    // R1
    shift_step_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        1'b1 |=> (r_q.stage[TOP:1] === $past(r_q.stage[TOP-1:0])) &&
                 (r_q.stage[0] === $past(ser_i)));

    // R6
    clear_zero_chk: assert property (@(posedge shift_clk)
        !clr_n |-> (r_q.stage == '0));
endmodule

// File: rtl/sreg_hold_reg.sv
module sreg_hold_reg #(
    parameter int unsigned WIDTH = sreg_pkg::SREG_DEF_WIDTH
) (
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] stage_i,
    output logic [WIDTH-1:0] hold_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d      = h_q;
        h_d.word = stage_i;
    end

    // No clear: the stored word survives a chain clear.
    always_ff @(posedge store_clk) begin
        h_q <= h_d;
    end

    assign hold_o = h_q.word;

    // R2
    store_copy_chk: assert property (@(posedge store_clk) disable iff (!clr_n)
        1'b1 |=> (h_q.word === $past(stage_i)));
endmodule

// File: rtl/sreg_latched_out.sv
module sreg_latched_out #(
    parameter int unsigned WIDTH = sreg_pkg::SREG_DEF_WIDTH
) (
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             ser_i,
    input  logic             oe_n,
    output wire  [WIDTH-1:0] par_o,
    output logic             ser_o
);
    import sreg_pkg::*;

    localparam int unsigned TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage;
    logic [WIDTH-1:0] held;
    drive_e           mode;

    sreg_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_i     (ser_i),
        .stage_o   (stage)
    );

    sreg_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .store_clk (store_clk),
        .clr_n     (clr_n),
        .stage_i   (stage),
        .hold_o    (held)
    );

    assign mode  = drive_e'(oe_n);
    assign ser_o = stage[TOP];

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
        assign par_o[gi] = (mode == DRIVE_ON) ? held[gi] : 1'bz;
    end

    // R5
    cascade_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        1'b1 |=> (ser_o === $past(stage[TOP-1])));
endmodule

// File: tb/sreg_latched_out_test.sv
module sreg_latched_out_test;
    logic clk = 1'b0;
    logic sh_en, st_en;
    logic clr_n, ser_i, oe_n;
    logic tb_drv;
    logic [7:0] tb_val;
    wire  [7:0] bus;
    logic ser_o;
    logic shift_clk, store_clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] stage_m;
    logic [7:0] hold_m;

    always #4 clk = ~clk;

    assign shift_clk = clk & sh_en;
    assign store_clk = clk & st_en;
    assign bus = tb_drv ? tb_val : 8'bz;

    sreg_latched_out uut (
        .shift_clk (shift_clk),
        .store_clk (store_clk),
        .clr_n     (clr_n),
        .ser_i     (ser_i),
        .oe_n      (oe_n),
        .par_o     (bus),
        .ser_o     (ser_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock pulse on the selected clocks; the bench model follows R1, R2, R6, R8.
    task automatic clock_edge(input logic sh, input logic st, input logic b);
        @(negedge clk);
        ser_i = b;
        sh_en = sh;
        st_en = st;
        @(negedge clk);
        sh_en = 1'b0;
        st_en = 1'b0;
        if (st) hold_m = stage_m;
        if (!clr_n) stage_m = 8'h00;
        else if (sh) stage_m = {stage_m[6:0], b};
        #1;
    endtask

    task automatic test_reset();
        clock_edge(1'b0, 1'b1, 1'b0);
        check("R6 reset parallel", bus, 8'h00);
        check("R6 reset serial", {7'd0, ser_o}, 8'h00);
        clr_n = 1'b1;
    endtask

    task automatic test_hold_update(input logic [7:0] pat);
        for (int k = 0; k < 8; k++) begin
            clock_edge(1'b1, 1'b0, pat[7-k]);
            check("R3 hold during shift", bus, hold_m);
            check("R5 serial tracks last stage", {7'd0, ser_o}, {7'd0, stage_m[7]});
        end
        clock_edge(1'b0, 1'b1, 1'b0);
        check("R1 R2 word after store", bus, pat);
    endtask

    task automatic test_enable();
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        tb_drv = 1'b1;
        tb_val = 8'hA5;
        #1;
        check("R4 released A5", bus, 8'hA5);
        tb_val = 8'h5A;
        #1;
        check("R4 released 5A", bus, 8'h5A);
        clock_edge(1'b1, 1'b0, ~stage_m[6]);
        check("R5 serial with oe_n high", {7'd0, ser_o}, {7'd0, stage_m[7]});
        tb_drv = 1'b0;
        #1;
        oe_n = 1'b0;
        #1;
        check("R4 driven again", bus, hold_m);
    endtask

    task automatic test_clear();
        @(negedge clk);
        clr_n = 1'b0;
        stage_m = 8'h00;
        #1;
        check("R6 async clear serial", {7'd0, ser_o}, 8'h00);
        check("R7 storage kept", bus, hold_m);
        clock_edge(1'b1, 1'b0, 1'b1);
        check("R6 shift ignored while clear", {7'd0, ser_o}, 8'h00);
        @(negedge clk);
        clr_n = 1'b1;
        clock_edge(1'b0, 1'b1, 1'b0);
        check("R7 cleared word after store", bus, 8'h00);
    endtask

    task automatic test_tied();
        for (int k = 0; k < 8; k++) clock_edge(1'b1, 1'b0, k[0] ^ k[2]);
        clock_edge(1'b0, 1'b1, 1'b0);
        check("R2 tied preload", bus, 8'h5A);
        clock_edge(1'b1, 1'b1, 1'b0);
        check("R8 tied edge 1", bus, 8'h5A);
        clock_edge(1'b1, 1'b1, 1'b1);
        check("R8 tied edge 2", bus, 8'hB4);
        clock_edge(1'b0, 1'b1, 1'b0);
        check("R8 tied final store", bus, 8'h69);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        sh_en = 1'b0;
        st_en = 1'b0;
        clr_n = 1'b0;
        ser_i = 1'b0;
        oe_n = 1'b0;
        tb_drv = 1'b0;
        tb_val = 8'h00;
        stage_m = 8'h00;
        hold_m = 8'h00;
        repeat (3) @(negedge clk);
        test_reset();
        test_hold_update(8'hB4);
        test_hold_update(8'h3C);
        test_enable();
        test_clear();
        test_tied();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule